// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a small set of sticky flags that tell software which kind of reset brought the chip up last. Five single-cycle event inputs feed it: power-on, external pin, supply brown-out, watchdog timeout and a reset commanded through the test access port. Each event sets its own flag, and the flag stays set until something clears it.

Software reads the register over a simple bus with an address, a write strobe, write data and read data. It clears the flags by writing zero to their bit positions early after start-up. After that, the flags present at the next start-up name the cause of that reset. A power-on event sets the power-on flag and wipes the other four. The power-on flag itself is cleared only by software.

Read data is combinational from the address. The register answers at one address, set by a parameter, and returns zero at every other address.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit positions are fixed: bit 0 power-on, bit 1 external, bit 2 brown-out, bit 3 watchdog, bit 4 test-port reset. An event pulse sets its bit, and the bit is visible on the next clock edge.
- R2: A set flag stays set across later cycles and later different events, until one of the clear conditions in R3 or R4 occurs.
- R3: A power-on event clears bits 1 to 4 and sets bit 0. A bit 1 to 4 event in the same cycle still sets its own bit.
- R4: A write at the register address with a 0 in bit i clears flag i. A 1 in bit i leaves flag i unchanged.
- R5: The power-on flag is cleared only by a software write of 0 to bit 0. The other events never clear it and never set it.
- R6: When an event and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: Bits 7 to 5 always read as 0, and writes to them have no effect.
- R8: A read at any address other than the register address returns 0. A write at another address changes no flag.
- R9: With the bus address at the register address, the read data shows the current flags in the same cycle, without a clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_evt | input | 1 | Power-on reset event pulse |
| ext_evt | input | 1 | External pin reset event pulse |
| bor_evt | input | 1 | Brown-out reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| jtag_evt | input | 1 | Test-port commanded reset event pulse |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data, 0 bits clear flags |
| bus_rdata | output | DATA_W | Read data |

## Verification
The properties assume that every event input is a pulse synchronous to clk. They also assume that a power-on event has occurred at least two cycles earlier, so they stay disabled until then. The bench opens every run with a power-on pulse, and it drops each event and the write strobe right after the edge that samples them. A behavioural model compares the read data after every clock. Stimulus covers single and combined events, collisions between an event and a write of 0, writes of 1, and accesses at a foreign address.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int NUM_SRC = 5;

    // Bit index of each reset source; software decodes these positions.
    typedef enum int {
        SRC_POR  = 0,
        SRC_EXT  = 1,
        SRC_BOR  = 2,
        SRC_WDT  = 3,
        SRC_JTAG = 4
    } src_idx_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/rst_cause_flag.sv
// One sticky flag: set has priority over every clear source.
module rst_cause_flag #(
    parameter bit CLR_ON_POR = 1'b1
) (
    input  logic clk,
    input  logic set_i,
    input  logic por_i,
    input  logic sw_clr_i,
    output logic flag_o
);

    logic flag_q;
    logic flag_d;
    logic hw_clr;

    always_comb begin
        hw_clr = CLR_ON_POR && por_i;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (hw_clr || sw_clr_i) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    always_ff @(posedge clk) begin
        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rst_cause_bus.sv
// Address decode, per-bit clear mask and zero-extended read mux.
module rst_cause_bus
    import rst_cause_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  src_vec_t          flags_i,
    output src_vec_t          sw_clr_o,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic sel;
    logic wr_hit;

    assign sel    = (bus_addr == REG_ADDR);
    assign wr_hit = sel && bus_wr;

    // Only the flag bits of the write data matter; upper bits are dropped.
    assign sw_clr_o = wr_hit ? ~bus_wdata[NUM_SRC-1:0] : '0;

    generate
        if (PAD_W > 0) begin : g_pad
            assign bus_rdata = sel ? {{PAD_W{1'b0}}, flags_i} : '0;
        end else begin : g_nopad
            assign bus_rdata = sel ? flags_i[DATA_W-1:0] : '0;
        end
    endgenerate

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              bor_evt,
    input  logic              wdt_evt,
    input  logic              jtag_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    src_vec_t evt_vec;
    src_vec_t sw_clr;
    src_vec_t flag_q;

    always_comb begin
        evt_vec           = '0;
        evt_vec[SRC_POR]  = por_evt;
        evt_vec[SRC_EXT]  = ext_evt;
        evt_vec[SRC_BOR]  = bor_evt;
        evt_vec[SRC_WDT]  = wdt_evt;
        evt_vec[SRC_JTAG] = jtag_evt;
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            // The power-on flag survives a power-on event; the rest do not.
            rst_cause_flag #(
                .CLR_ON_POR(i != SRC_POR)
            ) u_flag (
                .clk     (clk),
                .set_i   (evt_vec[i]),
                .por_i   (por_evt),
                .sw_clr_i(sw_clr[i]),
                .flag_o  (flag_q[i])
            );
        end
    endgenerate

    rst_cause_bus #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR)
    ) u_bus (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .flags_i  (flag_q),
        .sw_clr_o (sw_clr),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input logic              clk,
    input logic              por_evt,
    input logic              ext_evt,
    input logic              bor_evt,
    input logic              wdt_evt,
    input logic              jtag_evt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [4:0]        flags
);

    logic [1:0] arm = 2'b00;
    logic       live;
    logic [4:0] evts;
    logic       hit;

    always_ff @(posedge clk) begin
        arm <= {arm[0], arm[0] | por_evt};
    end

    assign live = arm[1];
    assign evts = {jtag_evt, wdt_evt, bor_evt, ext_evt, por_evt};
    assign hit  = bus_wr && (bus_addr == REG_ADDR);

    a_r1_event_sets: assert property (@(posedge clk) disable iff (!live)
        (evts != 5'd0) |=> ((flags & $past(evts)) == $past(evts)));

    a_r2_sticky: assert property (@(posedge clk) disable iff (!live)
        (!por_evt && !hit) |=> ((flags & $past(flags)) == $past(flags)));

    a_r3_por_wipes: assert property (@(posedge clk) disable iff (!live)
        por_evt |=> (flags[0] && (flags[4:1] == $past(evts[4:1]))));

    a_r4_write_clear: assert property (@(posedge clk) disable iff (!live)
        (hit && evts == 5'd0) |=> (flags == $past(flags & bus_wdata[4:0])));

    a_r5_por_flag_sw_only: assert property (@(posedge clk) disable iff (!live)
        $fell(flags[0]) |-> $past(hit && !bus_wdata[0]));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!live)
        (hit && evts != 5'd0) |=> ((flags & $past(evts)) == $past(evts)));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!live)
        bus_rdata[DATA_W-1:5] == '0);

    a_r8_foreign_zero: assert property (@(posedge clk) disable iff (!live)
        (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

    a_r9_read_now: assert property (@(posedge clk) disable iff (!live)
        (bus_addr == REG_ADDR) |-> (bus_rdata[4:0] == flags));

endmodule

bind rst_cause_reg rst_cause_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
) u_chk (
    .clk      (clk),
    .por_evt  (por_evt),
    .ext_evt  (ext_evt),
    .bor_evt  (bor_evt),
    .wdt_evt  (wdt_evt),
    .jtag_evt (jtag_evt),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .flags    (flag_q)
);

// File: tb/tb_rst_cause_reg.sv
`timescale 1ns/1ps
module tb_rst_cause_reg;

    localparam int         ADDR_W = 8;
    localparam int         DATA_W = 8;
    localparam logic [7:0] RADDR  = 8'h24;
    localparam logic [7:0] OADDR  = 8'h25;

    logic              clk = 1'b0;
    logic              por_evt = 0, ext_evt = 0, bor_evt = 0, wdt_evt = 0, jtag_evt = 0;
    logic [ADDR_W-1:0] bus_addr = RADDR;
    logic              bus_wr = 0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [4:0] model = 5'd0;

    always #2.5 clk = ~clk;

    rst_cause_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RADDR)) dut (
        .clk(clk), .por_evt(por_evt), .ext_evt(ext_evt), .bor_evt(bor_evt),
        .wdt_evt(wdt_evt), .jtag_evt(jtag_evt), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [7:0] exp, input string tag);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, bus_rdata, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, then read back at the register address and compare.
    task automatic step(input logic [4:0] ev, input logic wr,
                        input logic [7:0] addr, input logic [7:0] wd,
                        input string tag);
        logic [4:0] m;
        @(negedge clk);
        {jtag_evt, wdt_evt, bor_evt, ext_evt, por_evt} = ev;
        bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        m = model;
        if (ev[0]) m = m & 5'b00001;
        if (wr && addr == RADDR) m = m & wd[4:0];
        model = m | ev;
        #1;
        {jtag_evt, wdt_evt, bor_evt, ext_evt, por_evt} = 5'd0;
        bus_wr = 0; bus_addr = RADDR; bus_wdata = '0;
        #0.5;
        check({3'b000, model}, tag);
    endtask

    task automatic peek_foreign(input string tag);
        bus_addr = OADDR;
        #0.2;
        check(8'h00, tag);
        bus_addr = RADDR;
        #0.2;
    endtask

    initial begin
        step(5'b00001, 0, RADDR, 8'h00, "R3 power-on start");
        peek_foreign("R8 foreign read");
        step(5'b00010, 0, RADDR, 8'h00, "R1 external bit1");
        step(5'b00100, 0, RADDR, 8'h00, "R1 brown-out bit2");
        step(5'b01000, 0, RADDR, 8'h00, "R1 watchdog bit3");
        step(5'b10000, 0, RADDR, 8'h00, "R1 test-port bit4");
        for (int i = 0; i < 3; i++) step(5'b00000, 0, RADDR, 8'h00, "R2 hold");
        step(5'b00000, 1, RADDR, 8'hFF, "R4 write ones keep, R7 reserved zero");
        step(5'b00000, 1, RADDR, 8'hFE, "R5 write zero clears bit0");
        step(5'b00000, 1, OADDR, 8'h00, "R8 foreign write ignored");
        step(5'b00010, 0, RADDR, 8'h00, "R5 other event leaves bit0 clear");
        step(5'b00000, 1, RADDR, 8'hE0, "R4 clear all flags");
        step(5'b00000, 1, RADDR, 8'hE0, "R7 reserved write no effect");
        step(5'b01010, 0, RADDR, 8'h00, "R2 two events");
        step(5'b00001, 0, RADDR, 8'h00, "R3 power-on wipes others");
        step(5'b00100, 1, RADDR, 8'h00, "R6 set beats write zero");
        step(5'b00001, 1, RADDR, 8'h00, "R6 power-on beats write zero");
        step(5'b11111, 0, RADDR, 8'h00, "R1 all events");
        step(5'b01001, 0, RADDR, 8'h00, "R3 power-on with watchdog");
        step(5'b00000, 1, RADDR, 8'hF7, "R4 clear bit3 only");
        peek_foreign("R8 foreign read after writes");
        @(negedge clk);
        #0.5;
        check({3'b000, model}, "R9 same-cycle read");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule